// File: doc/BRIEF.md
# Even Ratio Clock Divider

This block derives a slower clock from one source clock by an even ratio picked from eight settings: 2, 4, 6, 8, 10, 12, 14 or 16. A 3-bit code selects the ratio, and the output always has a 50% duty cycle. The main use is to feed logic that captures on both edges of the divided clock. At ratio 2 that logic keeps the throughput of the source clock while its clock net toggles half as often.

A dedicated divider reset holds the output low and clears the internal phase counter. This reset is sampled on the falling edge of the source clock, so a pulse on it counts only if it covers a falling edge. After release, the divider restarts in a known phase. A new ratio code is picked up only at an output transition, so a change mid-phase never produces a runt pulse.

Top module: `even_clk_div`

## Requirements
- R1: The ratio code c (0 to 7) selects a division ratio N = 2*(c+1), so the output period is N source clock cycles.
- R2: With the divider running, the output is high for exactly N/2 source cycles and low for exactly N/2 source cycles.
- R3: While the sampled divider reset is high, the output is low and the phase counter is zero. This includes a reset that arrives while the output is high.
- R4: The divider reset is sampled only on falling source edges. A pulse that covers a rising edge but no falling edge has no effect. A pulse that covers one falling edge forces the output low at the next rising edge.
- R5: After the first falling edge that samples the reset low, the output first rises on the (N/2)-th rising source edge.
- R6: A new ratio code is taken only at an output transition. The phase in progress keeps the old length, and the phases after it use the new one.
- R7: The two extreme codes work at the limits: code 0 gives divide-by-2 with one-cycle phases, and code 7 gives divide-by-16 with the counter reaching 7 and never beyond the held code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock being divided |
| div_rst | input | 1 | Divider reset, active high, sampled on the falling edge of src_clk |
| ratio_sel | input | 3 | Ratio code c, ratio N = 2*(c+1) |
| div_clk | output | 1 | Divided clock, 50% duty cycle |

## Verification
The hardest cases to reach from the ports are the reset pulses that fall between clock edges, and a ratio change landing inside a phase that is already running. The stimulus places reset pulses at sub-cycle offsets. One pulse straddles only a rising edge and must leave the phase train untouched. Another straddles only a falling edge during a high phase and must force the output low and restart the phase count. Ratio changes are timed from the monitor's view of completed phases: one comes right after a transition and one three cycles into a long phase. The scoreboard then expects the phase in progress to finish at the old length before the new one starts.

// File: rtl/ecd_pkg.sv
`timescale 1ns/1ps
package ecd_pkg;
   // width of the ratio code used when the caller does not override it
   localparam int unsigned ECD_SEL_W_DEFAULT = 3;

   // division ratio produced by a ratio code
   function automatic int unsigned ratio_of(input int unsigned code);
      return 2 * (code + 1);
   endfunction

   // number of source cycles spent in one output level
   function automatic int unsigned half_of(input int unsigned code);
      return ratio_of(code) / 2;
   endfunction
endpackage

// File: rtl/ecd_rst_sample.sv
`timescale 1ns/1ps
// Captures the divider reset on the chosen edge of the source clock.
module ecd_rst_sample #(
   parameter bit ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_in,
   output logic rst_q
);
   logic smp;

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge clk) begin
            smp <= rst_in;
         end
      end else begin : g_rise
         always_ff @(posedge clk) begin
            smp <= rst_in;
         end
      end
   endgenerate

   assign rst_q = smp;
endmodule

// File: rtl/ecd_ratio_hold.sv
`timescale 1ns/1ps
// Holds the ratio code in effect; reloads only when told to.
module ecd_ratio_hold #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             load,
   input  logic [SEL_W-1:0] sel_in,
   output logic [SEL_W-1:0] code_q
);
   always_ff @(posedge clk) begin
      if (load) begin
         code_q <= sel_in;
      end
   end
endmodule

// File: rtl/ecd_phase_count.sv
`timescale 1ns/1ps
// Counts source cycles within one output level; flags the last one.
module ecd_phase_count #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [SEL_W-1:0] limit,
   output logic             wrap,
   output logic [SEL_W-1:0] cnt
);
   localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

   assign wrap = (cnt == limit);

   always_ff @(posedge clk) begin
      if (clr || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/ecd_out_toggle.sv
`timescale 1ns/1ps
// Output level flop: cleared low, inverted on each phase end.
module ecd_out_toggle (
   input  logic clk,
   input  logic clr,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk) begin
      if (clr) begin
         q <= 1'b0;
      end else if (flip) begin
         q <= ~q;
      end
   end
endmodule

// File: rtl/even_clk_div.sv
`timescale 1ns/1ps
module even_clk_div #(
   parameter int unsigned SEL_W       = ecd_pkg::ECD_SEL_W_DEFAULT,
   parameter bit          RST_ON_FALL = 1'b1
) (
   input  logic             src_clk,
   input  logic             div_rst,
   input  logic [SEL_W-1:0] ratio_sel,
   output logic             div_clk
);
   localparam int unsigned MAX_CODE  = (1 << SEL_W) - 1;
   localparam int unsigned MAX_RATIO = ecd_pkg::ratio_of(MAX_CODE);

   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_width
         $error("even_clk_div: SEL_W must lie in 1..8");
      end
      if (MAX_RATIO != (2 << SEL_W)) begin : g_bad_ratio
         $error("even_clk_div: ratio table inconsistent with SEL_W");
      end
   endgenerate

   logic             rst_q;
   logic             wrap;
   logic [SEL_W-1:0] cnt;
   logic [SEL_W-1:0] code_l;

   ecd_rst_sample #(.ON_FALL(RST_ON_FALL)) u_rst (
      .clk    (src_clk),
      .rst_in (div_rst),
      .rst_q  (rst_q)
   );

   // new ratio accepted only in reset or at a phase boundary
   ecd_ratio_hold #(.SEL_W(SEL_W)) u_hold (
      .clk    (src_clk),
      .load   (rst_q | wrap),
      .sel_in (ratio_sel),
      .code_q (code_l)
   );

   ecd_phase_count #(.SEL_W(SEL_W)) u_cnt (
      .clk   (src_clk),
      .clr   (rst_q),
      .limit (code_l),
      .wrap  (wrap),
      .cnt   (cnt)
   );

   ecd_out_toggle u_out (
      .clk  (src_clk),
      .clr  (rst_q),
      .flip (wrap),
      .q    (div_clk)
   );
endmodule

// File: rtl/even_clk_div_chk.sv
`timescale 1ns/1ps
module even_clk_div_chk #(
   parameter int unsigned SEL_W = 3
) (
   input logic             src_clk,
   input logic             div_rst,
   input logic [SEL_W-1:0] ratio_sel,
   input logic             div_clk,
   input logic             rst_q,
   input logic [SEL_W-1:0] cnt,
   input logic [SEL_W-1:0] code_l
);
   // R3, R4: reset seen on a falling edge clears state by the next falling edge
   p_clear_after_fall_r4: assert property (@(negedge src_clk)
      div_rst |=> (!div_clk && cnt == '0));

   // R7: the counter never passes the held code
   p_cnt_bound_r7: assert property (@(posedge src_clk) disable iff (rst_q)
      cnt <= code_l);

   // R2: a phase end inverts the output
   p_wrap_toggle_r2: assert property (@(posedge src_clk) disable iff (rst_q)
      (cnt == code_l) |=> (div_clk != $past(div_clk)));

   // R2: inside a phase the output holds
   p_mid_hold_r2: assert property (@(posedge src_clk) disable iff (rst_q)
      (cnt != code_l) |=> $stable(div_clk));

   // R6: held code is frozen inside a phase
   p_code_frozen_r6: assert property (@(posedge src_clk) disable iff (rst_q)
      (cnt != code_l) |=> $stable(code_l));

   // R6: at a phase end the presented code is adopted
   p_code_taken_r6: assert property (@(posedge src_clk) disable iff (rst_q)
      (cnt == code_l) |=> (code_l == $past(ratio_sel)));
endmodule

bind even_clk_div even_clk_div_chk #(.SEL_W(SEL_W)) u_chk (
   .src_clk   (src_clk),
   .div_rst   (div_rst),
   .ratio_sel (ratio_sel),
   .div_clk   (div_clk),
   .rst_q     (rst_q),
   .cnt       (cnt),
   .code_l    (code_l)
);

// File: tb/test_even_clk_div.sv
`timescale 1ns/1ps
module test_even_clk_div;
   typedef struct {
      bit    lvl;
      int    len;
      string req;
   } phase_t;

   logic       src_clk = 1'b0;
   logic       div_rst = 1'b1;
   logic [2:0] ratio_sel = 3'd0;
   wire        div_clk;

   int     n_cmp = 0;
   int     n_bad = 0;
   int     n_done = 0;
   bit     mon_en = 1'b0;
   phase_t exp_q[$];

   always #2.5 src_clk = ~src_clk;

   even_clk_div i_even_clk_div (
      .src_clk   (src_clk),
      .div_rst   (div_rst),
      .ratio_sel (ratio_sel),
      .div_clk   (div_clk)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push_phases(input int half, input int count, input bit first_lvl,
                              input string req);
      for (int i = 0; i < count; i++) begin
         phase_t p;
         p.lvl = first_lvl ^ bit'(i % 2);
         p.len = half;
         p.req = req;
         exp_q.push_back(p);
      end
   endtask

   // reset with a code, verify output held low, then release
   task automatic start_case(input int code, input bit watch);
      @(posedge src_clk); #1;
      mon_en    = 1'b0;
      div_rst   = 1'b1;
      ratio_sel = 3'(code);
      for (int i = 0; i < 3; i++) begin
         @(posedge src_clk); #1;
         check(div_clk === 1'b0, "R3", int'(div_clk), 0);
      end
      div_rst = 1'b0;
      mon_en  = watch;
   endtask

   // monitor: measures each output level length, compares with queue
   initial begin
      bit     prev;
      int     len;
      phase_t e;
      prev = 1'b0;
      len  = 0;
      forever begin
         @(negedge src_clk); #1;
         if (!mon_en) begin
            prev = 1'b0;
            len  = 0;
         end else if (div_clk === prev) begin
            len++;
         end else begin
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               n_cmp++;
               if (e.lvl !== prev || e.len != len) begin
                  n_bad++;
                  $display("FAIL %s: phase level %0d length %0d, expected level %0d length %0d",
                           e.req, prev, len, e.lvl, e.len);
               end
               n_done++;
            end
            prev = div_clk;
            len  = 1;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge src_clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int target;
      int k;

      // R1 R5 R7: code 0, divide by 2, first low phase one cycle
      target = n_done + 6;
      push_phases(1, 6, 1'b0, "R1/R5/R7 code0");
      start_case(0, 1'b1);
      wait (n_done == target);

      // R1 R2: code 3, divide by 8
      target = n_done + 4;
      push_phases(4, 4, 1'b0, "R1/R2 code3");
      start_case(3, 1'b1);
      wait (n_done == target);

      // R7: code 7, divide by 16
      target = n_done + 4;
      push_phases(8, 4, 1'b0, "R7 code7");
      start_case(7, 1'b1);
      wait (n_done == target);

      // R4: pulse covering only a rising edge is ignored
      target = n_done + 6;
      push_phases(3, 6, 1'b0, "R4 rise-only pulse");
      start_case(2, 1'b1);
      repeat (4) @(posedge src_clk);
      #4 div_rst = 1'b1;
      @(posedge src_clk); #1;
      div_rst = 1'b0;
      wait (n_done == target);

      // R6: change right after a transition, in-progress phase keeps old length
      target = n_done + 6;
      push_phases(2, 3, 1'b0, "R6 old length");
      push_phases(6, 3, 1'b1, "R6 new length");
      start_case(1, 1'b1);
      wait (n_done == 2 + target - 6);
      @(posedge src_clk); #1;
      ratio_sel = 3'd5;
      wait (n_done == target);

      // R6: change deep inside a long phase
      target = n_done + 6;
      push_phases(7, 2, 1'b0, "R6 long phase kept");
      push_phases(1, 4, 1'b0, "R6 short after change");
      start_case(6, 1'b1);
      wait (n_done == 1 + target - 6);
      repeat (3) @(posedge src_clk);
      #1 ratio_sel = 3'd0;
      wait (n_done == target);

      // R3 R4 R5: falling-edge pulse during a high phase, then restart timing
      start_case(6, 1'b0);
      k = 0;
      do begin
         @(posedge src_clk); #1;
         k++;
      end while (div_clk !== 1'b1 && k < 40);
      check(k == 7, "R5", k, 7);
      div_rst = 1'b1;
      #2 div_rst = 1'b0;
      @(posedge src_clk); #1;
      check(div_clk === 1'b0, "R4 fall-edge pulse forces low (R3)", int'(div_clk), 0);
      k = 0;
      do begin
         @(posedge src_clk); #1;
         k++;
      end while (div_clk !== 1'b1 && k < 40);
      check(k == 7, "R5 restart after pulse", k, 7);

      repeat (4) @(posedge src_clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule